// File: doc/BRIEF.md
# Timing Master Role Controller

This block is the control state machine of a timing board that can serve either as the primary or as the secondary source of a redundant pair of system clocks. It does not contain the PLL. It drives three control lines of an external PLL: the holdover enable, the loop bandwidth select and the reference source select. It also drives the output enables of the backplane sync buses. Each enable is gated by authorization from the shelf manager and by the validity of the clock being driven.

As secondary, the board tracks the primary's system clock with a wide loop bandwidth and drives the redundant buses. When the primary clock is reported out of specification, the block runs a fixed promotion sequence:

1. Enter holdover at once.
2. After a settle time, narrow the loop bandwidth.
3. After another settle time, move the PLL reference to a valid network reference.
4. When the PLL reports lock, leave holdover and take the primary role.

A lock that never arrives, or the lack of any valid network reference, ends in a sticky alarm.

As primary, the board follows the shelf manager's choice of network reference. If that reference fails, the board moves to the other network reference without entering holdover.

Top module: `timing_role_ctrl`

## Requirements
- R1: During and after reset, holdoverEn is 0. With cfgPrimary=1 the block starts as primary: isPrimary=1, loopBwLow=1, and pllRefSel selects the chosen network reference. With cfgPrimary=0 it starts as secondary: isPrimary=0, loopBwLow=0, pllRefSel=2'b00. The encoding of pllRefSel is 2'b00 for the system clock bus, 2'b01 for network reference A and 2'b10 for network reference B. netRefSel=0 chooses A and netRefSel=1 chooses B.
- R2: When a secondary in idle sees primaryFail, holdoverEn is 1 on the next cycle and seqStep is 1. loopBwLow and pllRefSel are unchanged.
- R3: SETTLE_CYCLES cycles after holdover starts, loopBwLow becomes 1 and seqStep becomes 2. holdoverEn stays 1.
- R4: SETTLE_CYCLES cycles after the bandwidth change, pllRefSel moves to the chosen network reference if it is valid, or otherwise to the other one if that is valid. seqStep becomes 3.
- R5: In step 3, the cycle after pllLocked is seen, holdoverEn is 0, isPrimary is 1 and seqStep is 0.
- R6: The block enters alarm in two cases: no pllLocked within LOCK_TIMEOUT cycles of entering step 3, or neither network reference valid at the end of step 2. In alarm, seqStep is 7, holdoverEn stays 1 and isPrimary stays 0. Alarm holds until reset.
- R7: In a primary, when the current network reference is invalid and the other one is valid, pllRefSel moves to the other one on the next cycle. holdoverEn stays 0.
- R8: actBusOe is high only when authSys is high, the block is primary and ownClkBad is low. redBusOe is high only when authSys is high, the block is secondary and not in alarm.
- R9: netBusOe[i] is high only when authNet[i] is high and extRefValid is high.
- R10: A primaryFail pulse has no effect on a block that is already primary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfgPrimary | input | 1 | Role taken at reset (1 = primary) |
| primaryFail | input | 1 | Primary system clock out of specification |
| ownClkBad | input | 1 | This board's own output clock is faulty |
| netRefSel | input | 1 | Shelf manager's network reference choice (0 = A, 1 = B) |
| netRefValid | input | 2 | Validity of network references A (bit 0) and B (bit 1) |
| pllLocked | input | 1 | PLL lock indication |
| authSys | input | 1 | Authorization to drive the system clock buses |
| authNet | input | 2 | Authorization to drive network reference bus A/B |
| extRefValid | input | 1 | This board's own external reference is valid |
| holdoverEn | output | 1 | PLL holdover enable |
| loopBwLow | output | 1 | PLL low (filtering) bandwidth select |
| pllRefSel | output | 2 | PLL reference source select |
| actBusOe | output | 1 | Output enable for the active system clock buses |
| redBusOe | output | 1 | Output enable for the redundant system clock buses |
| netBusOe | output | 2 | Output enable for network reference bus A/B |
| isPrimary | output | 1 | Current role |
| seqStep | output | 3 | Sequence step: 0 idle, 1 holdover, 2 bandwidth, 3 reference, 7 alarm |
| alarm | output | 1 | Sticky alarm flag |

## Verification
The assertions assume three things about the inputs: reset is held for at least one clock, cfgPrimary is stable while reset is low, and the PLL never reports a meaningful lock outside step 3 of the sequence. The bench sets every input at the falling clock edge and holds cfgPrimary steady for the whole reset window. It raises pllLocked only once the reference step has been reached, and pulses primaryFail for a single cycle. Each scenario starts again from reset, so no alarm carries over from one scenario to the next.

// File: rtl/trc_pkg.sv
package trc_pkg;

  typedef enum logic [2:0] {
    ST_SEC   = 3'd0,
    ST_PRI   = 3'd1,
    ST_HOLD  = 3'd2,
    ST_BW    = 3'd3,
    ST_REF   = 3'd4,
    ST_ALARM = 3'd5
  } ctrlState_t;

  typedef struct packed {
    logic       timerClr;
    logic       holdSet;
    logic       holdClr;
    logic       bwLowSet;
    logic       refLoad;
    logic [1:0] refVal;
    logic       promote;
  } dpStrobe_t;

  localparam logic [1:0] REF_SYS  = 2'b00;
  localparam logic [1:0] REF_NETA = 2'b01;
  localparam logic [1:0] REF_NETB = 2'b10;

endpackage

// File: rtl/trc_datapath.sv
module trc_datapath
  import trc_pkg::*;
#(
  parameter int SETTLE_CYCLES = 16,
  parameter int LOCK_TIMEOUT  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgPrimary,
  input  logic       netRefSel,
  input  dpStrobe_t  strobe,
  output logic       settleDone,
  output logic       lockExpired,
  output logic       holdoverEn,
  output logic       loopBwLow,
  output logic [1:0] pllRefSel,
  output logic       isPrimary
);

  localparam int MAXT = (SETTLE_CYCLES > LOCK_TIMEOUT) ? SETTLE_CYCLES : LOCK_TIMEOUT;
  localparam int TW   = $clog2(MAXT + 1);
  localparam logic [TW-1:0] SETTLE_LAST = TW'(SETTLE_CYCLES - 1);
  localparam logic [TW-1:0] LOCK_LAST   = TW'(LOCK_TIMEOUT - 1);
  localparam logic [TW-1:0] T_MAX       = TW'(MAXT);

  logic [TW-1:0] timer;

  // Saturating cycle counter, restarted by the control
  always_ff @(posedge clk) begin
    if (!rst_n || strobe.timerClr) timer <= '0;
    else if (timer != T_MAX)       timer <= timer + 1'b1;
  end

  assign settleDone  = (timer == SETTLE_LAST);
  assign lockExpired = (timer == LOCK_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holdoverEn <= 1'b0;
      loopBwLow  <= cfgPrimary;
      pllRefSel  <= cfgPrimary ? (netRefSel ? REF_NETB : REF_NETA) : REF_SYS;
      isPrimary  <= cfgPrimary;
    end else begin
      if (strobe.holdSet)       holdoverEn <= 1'b1;
      else if (strobe.holdClr)  holdoverEn <= 1'b0;
      if (strobe.bwLowSet)      loopBwLow  <= 1'b1;
      if (strobe.refLoad)       pllRefSel  <= strobe.refVal;
      if (strobe.promote)       isPrimary  <= 1'b1;
    end
  end

endmodule

// File: rtl/trc_ctrl.sv
module trc_ctrl
  import trc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgPrimary,
  input  logic       primaryFail,
  input  logic       netRefSel,
  input  logic [1:0] netRefValid,
  input  logic       pllLocked,
  input  logic       settleDone,
  input  logic       lockExpired,
  input  logic [1:0] curRef,
  output dpStrobe_t  strobe,
  output logic [2:0] seqStep,
  output logic       alarm
);

  ctrlState_t state, nextState;

  logic curIdx;
  assign curIdx = curRef[1];

  always_ff @(posedge clk) begin
    if (!rst_n) state <= cfgPrimary ? ST_PRI : ST_SEC;
    else        state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_SEC: if (primaryFail) begin
        strobe.holdSet  = 1'b1;
        strobe.timerClr = 1'b1;
        nextState       = ST_HOLD;
      end
      ST_HOLD: if (settleDone) begin
        strobe.bwLowSet = 1'b1;
        strobe.timerClr = 1'b1;
        nextState       = ST_BW;
      end
      ST_BW: if (settleDone) begin
        strobe.timerClr = 1'b1;
        if (netRefValid[netRefSel]) begin
          strobe.refLoad = 1'b1;
          strobe.refVal  = netRefSel ? REF_NETB : REF_NETA;
          nextState      = ST_REF;
        end else if (netRefValid[~netRefSel]) begin
          strobe.refLoad = 1'b1;
          strobe.refVal  = netRefSel ? REF_NETA : REF_NETB;
          nextState      = ST_REF;
        end else begin
          nextState      = ST_ALARM;
        end
      end
      ST_REF: begin
        if (pllLocked) begin
          strobe.holdClr = 1'b1;
          strobe.promote = 1'b1;
          nextState      = ST_PRI;
        end else if (lockExpired) begin
          nextState      = ST_ALARM;
        end
      end
      ST_PRI: if (curRef != REF_SYS && !netRefValid[curIdx] && netRefValid[~curIdx]) begin
        strobe.refLoad = 1'b1;
        strobe.refVal  = curIdx ? REF_NETA : REF_NETB;
      end
      default: nextState = ST_ALARM;
    endcase
  end

  always_comb begin
    unique case (state)
      ST_HOLD:  seqStep = 3'd1;
      ST_BW:    seqStep = 3'd2;
      ST_REF:   seqStep = 3'd3;
      ST_ALARM: seqStep = 3'd7;
      default:  seqStep = 3'd0;
    endcase
  end

  assign alarm = (state == ST_ALARM);

endmodule

// File: rtl/timing_role_ctrl.sv
module timing_role_ctrl
  import trc_pkg::*;
#(
  parameter int SETTLE_CYCLES = 16,
  parameter int LOCK_TIMEOUT  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgPrimary,
  input  logic       primaryFail,
  input  logic       ownClkBad,
  input  logic       netRefSel,
  input  logic [1:0] netRefValid,
  input  logic       pllLocked,
  input  logic       authSys,
  input  logic [1:0] authNet,
  input  logic       extRefValid,
  output logic       holdoverEn,
  output logic       loopBwLow,
  output logic [1:0] pllRefSel,
  output logic       actBusOe,
  output logic       redBusOe,
  output logic [1:0] netBusOe,
  output logic       isPrimary,
  output logic [2:0] seqStep,
  output logic       alarm
);

  dpStrobe_t strobe;
  logic settleDone, lockExpired;

  trc_ctrl u_ctrl (
    .clk, .rst_n, .cfgPrimary, .primaryFail, .netRefSel, .netRefValid,
    .pllLocked, .settleDone, .lockExpired, .curRef(pllRefSel),
    .strobe, .seqStep, .alarm
  );

  trc_datapath #(.SETTLE_CYCLES(SETTLE_CYCLES), .LOCK_TIMEOUT(LOCK_TIMEOUT)) u_dp (
    .clk, .rst_n, .cfgPrimary, .netRefSel, .strobe, .settleDone, .lockExpired,
    .holdoverEn, .loopBwLow, .pllRefSel, .isPrimary
  );

  assign actBusOe = authSys & isPrimary & ~ownClkBad;
  assign redBusOe = authSys & ~isPrimary & ~alarm;

  for (genvar i = 0; i < 2; i++) begin : g_netOe
    assign netBusOe[i] = authNet[i] & extRefValid;
  end

endmodule

// File: rtl/timing_role_ctrl_chk.sv
module timing_role_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       primaryFail,
  input logic       extRefValid,
  input logic       holdoverEn,
  input logic       loopBwLow,
  input logic [1:0] pllRefSel,
  input logic       actBusOe,
  input logic       redBusOe,
  input logic [1:0] netBusOe,
  input logic       isPrimary,
  input logic [2:0] seqStep,
  input logic       alarm
);

  // R2
  hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holdoverEn) |-> (seqStep == 3'd1) && !isPrimary);

  // R3
  bw_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loopBwLow) |-> holdoverEn && seqStep == 3'd2);

  // R5
  promote_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isPrimary) |-> !holdoverEn && loopBwLow && pllRefSel != 2'b00);

  // R6
  alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |=> alarm && holdoverEn && !isPrimary);

  // R7
  primary_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isPrimary |-> !holdoverEn);

  // R8
  oe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(actBusOe && redBusOe));

  // R9
  net_oe_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !extRefValid |-> netBusOe == 2'b00);

  // R10
  primary_ignores_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isPrimary && primaryFail) |=> isPrimary && seqStep == 3'd0);

endmodule

bind timing_role_ctrl timing_role_ctrl_chk u_chk (
  .clk, .rst_n, .primaryFail, .extRefValid, .holdoverEn, .loopBwLow, .pllRefSel,
  .actBusOe, .redBusOe, .netBusOe, .isPrimary, .seqStep, .alarm
);

// File: tb/timing_role_ctrl_tb.sv
module timing_role_ctrl_tb;

  localparam int SETTLE = 16;
  localparam int LOCKTO = 64;

  logic clk = 1'b0;
  logic rst_n, cfgPrimary, primaryFail, ownClkBad, netRefSel, pllLocked, authSys, extRefValid;
  logic [1:0] netRefValid, authNet;
  logic holdoverEn, loopBwLow, actBusOe, redBusOe, isPrimary, alarm;
  logic [1:0] pllRefSel, netBusOe;
  logic [2:0] seqStep;

  int testsRun = 0;
  int testsFailed = 0;

  always #5 clk = ~clk;

  timing_role_ctrl #(.SETTLE_CYCLES(SETTLE), .LOCK_TIMEOUT(LOCKTO)) u_dut (
    .clk, .rst_n, .cfgPrimary, .primaryFail, .ownClkBad, .netRefSel, .netRefValid,
    .pllLocked, .authSys, .authNet, .extRefValid, .holdoverEn, .loopBwLow,
    .pllRefSel, .actBusOe, .redBusOe, .netBusOe, .isPrimary, .seqStep, .alarm
  );

  task automatic check(input string req, input string what, input int actual, input int expected);
    testsRun++;
    if (actual != expected) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  task automatic stepN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset(input logic pri, input logic sel);
    @(negedge clk);
    rst_n = 1'b0; cfgPrimary = pri; netRefSel = sel; primaryFail = 1'b0;
    ownClkBad = 1'b0; netRefValid = 2'b11; pllLocked = 1'b0;
    authSys = 1'b1; authNet = 2'b00; extRefValid = 1'b0;
    stepN(3);
    rst_n = 1'b1;
    stepN(1);
  endtask

  // Bring a secondary through steps 1..3; leaves it in step 3
  task automatic runToRefStep();
    primaryFail = 1'b1;
    stepN(1);
    primaryFail = 1'b0;
    stepN(2 * SETTLE);
  endtask

  task automatic testResetStates();
    doReset(1'b1, 1'b0);
    check("R1", "pri isPrimary", isPrimary, 1);
    check("R1", "pri bw", loopBwLow, 1);
    check("R1", "pri ref", pllRefSel, 1);
    check("R1", "pri hold", holdoverEn, 0);
    doReset(1'b0, 1'b1);
    check("R1", "sec isPrimary", isPrimary, 0);
    check("R1", "sec bw", loopBwLow, 0);
    check("R1", "sec ref", pllRefSel, 0);
    check("R1", "sec step", seqStep, 0);
  endtask

  task automatic testPromotion();
    doReset(1'b0, 1'b1);
    primaryFail = 1'b1;
    stepN(1);
    primaryFail = 1'b0;
    check("R2", "hold", holdoverEn, 1);
    check("R2", "step", seqStep, 1);
    check("R2", "bw unchanged", loopBwLow, 0);
    check("R2", "ref unchanged", pllRefSel, 0);
    check("R8", "redOe in hold", redBusOe, 1);
    stepN(SETTLE - 1);
    check("R3", "bw before settle", loopBwLow, 0);
    stepN(1);
    check("R3", "bw after settle", loopBwLow, 1);
    check("R3", "step", seqStep, 2);
    check("R3", "hold kept", holdoverEn, 1);
    stepN(SETTLE - 1);
    check("R4", "ref before settle", pllRefSel, 0);
    stepN(1);
    check("R4", "ref B chosen", pllRefSel, 2);
    check("R4", "step", seqStep, 3);
    pllLocked = 1'b1;
    stepN(1);
    check("R5", "promoted", isPrimary, 1);
    check("R5", "hold released", holdoverEn, 0);
    check("R5", "step", seqStep, 0);
    check("R8", "actOe", actBusOe, 1);
    check("R8", "redOe", redBusOe, 0);
  endtask

  task automatic testFallbackRef();
    doReset(1'b0, 1'b1);
    netRefValid = 2'b01;
    runToRefStep();
    check("R4", "fallback to A", pllRefSel, 1);
  endtask

  task automatic testLockTimeout();
    doReset(1'b0, 1'b0);
    runToRefStep();
    stepN(LOCKTO - 1);
    check("R6", "no alarm before timeout", alarm, 0);
    stepN(1);
    check("R6", "alarm at timeout", alarm, 1);
    check("R6", "step 7", seqStep, 7);
    pllLocked = 1'b1;
    stepN(5);
    check("R6", "alarm sticky", alarm, 1);
    check("R6", "hold kept", holdoverEn, 1);
    check("R6", "not primary", isPrimary, 0);
    check("R8", "redOe off in alarm", redBusOe, 0);
  endtask

  task automatic testNoRef();
    doReset(1'b0, 1'b0);
    netRefValid = 2'b00;
    runToRefStep();
    check("R6", "alarm no ref", alarm, 1);
  endtask

  task automatic testPrimarySwap();
    doReset(1'b1, 1'b0);
    netRefValid = 2'b10;
    stepN(1);
    check("R7", "swapped to B", pllRefSel, 2);
    check("R7", "no hold", holdoverEn, 0);
    netRefValid = 2'b01;
    stepN(1);
    check("R7", "swapped back to A", pllRefSel, 1);
    primaryFail = 1'b1;
    stepN(1);
    primaryFail = 1'b0;
    stepN(1);
    check("R10", "still primary", isPrimary, 1);
    check("R10", "no hold", holdoverEn, 0);
    check("R10", "step idle", seqStep, 0);
  endtask

  task automatic testEnables();
    doReset(1'b1, 1'b0);
    check("R8", "actOe authorized", actBusOe, 1);
    ownClkBad = 1'b1;
    stepN(1);
    check("R8", "actOe own fault", actBusOe, 0);
    ownClkBad = 1'b0; authSys = 1'b0;
    stepN(1);
    check("R8", "actOe unauth", actBusOe, 0);
    authNet = 2'b10; extRefValid = 1'b1;
    stepN(1);
    check("R9", "netOe B", netBusOe, 2);
    extRefValid = 1'b0;
    stepN(1);
    check("R9", "netOe ext invalid", netBusOe, 0);
  endtask

  initial begin
    fork
      begin
        testResetStates();
        testPromotion();
        testFallbackRef();
        testLockTimeout();
        testNoRef();
        testPrimarySwap();
        testEnables();
      end
      begin
        repeat (20000) @(posedge clk);
        testsRun++;
        testsFailed++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule